// File: doc/BRIEF.md
# Four-Bit Accumulator ALU Datapath

This block is the arithmetic core of a minimal processor datapath. A 4-bit arithmetic/logic unit takes its first operand from the data bus. Its second operand is the accumulator register, fed back from the register output. On a clock edge with the load strobe high, the accumulator captures the unit's result. This lets a sequence of adds, subtracts or logic steps build up a value over several cycles.

The operation is not chosen by an opcode. Three independent control lines pick it:

- an active-low line that drops the accumulator from the operation (bus operand alone);
- an active-low line that complements the bus operand;
- a line that picks bitwise logic instead of addition.

The accumulator can also be placed onto the data bus through an explicit output enable. While it drives the bus, the accumulator value also becomes the bus operand seen by the unit. A combinational flag reports when the accumulator drive and an external drive are both asserted.

Top module: `acc_alu_dp`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) clears the accumulator to 0.
- R2: The bus operand A equals acc_q when acc_to_bus is 1 and equals bus_in otherwise; operand B is always acc_q.
- R3: With logic_sel=0, a_only_n=0, invert_n=1, alu_y equals A (pass-through).
- R4: With logic_sel=0, a_only_n=1, invert_n=1, alu_y equals (A + B) mod 16; the carry out is discarded.
- R5: With logic_sel=0, a_only_n=1, invert_n=0, alu_y equals (B - A) mod 16, formed as B + ~A + 1.
- R6: With logic_sel=0, a_only_n=0, invert_n=0, alu_y equals (0 - A) mod 16 (two's-complement negate).
- R7: With logic_sel=1, alu_y equals A' & B', where A' is A when invert_n=1 or ~A when invert_n=0, and B' is B when a_only_n=1 or all ones when a_only_n=0. The four logic settings therefore give A AND B, ~A AND B, A, and ~A.
- R8: At a rising edge with load_acc=1, acc_q takes the alu_y value present before that edge; with load_acc=0 acc_q holds.
- R9: When acc_to_bus=1, bus_oe=1 and bus_out=acc_q. When acc_to_bus=0, bus_oe=0 and bus_out=0.
- R10: bus_conflict is 1 exactly when acc_to_bus and ext_drive are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_in | input | 4 | Value driven onto the data bus by another source |
| ext_drive | input | 1 | Another source claims the data bus |
| a_only_n | input | 1 | Active-low: drop accumulator operand |
| invert_n | input | 1 | Active-low: complement bus operand |
| logic_sel | input | 1 | 1 = bitwise logic, 0 = addition |
| load_acc | input | 1 | Capture alu_y into the accumulator at the clock edge |
| acc_to_bus | input | 1 | Place the accumulator on the data bus |
| alu_y | output | 4 | Combinational ALU result |
| acc_q | output | 4 | Accumulator contents |
| bus_out | output | 4 | Accumulator value toward the bus, 0 when not enabled |
| bus_oe | output | 1 | Output enable for bus_out |
| bus_conflict | output | 1 | Accumulator and external source both drive the bus |

## Verification
Two functions can fall in the same cycle: driving the accumulator onto the bus and loading the accumulator. When they do, the accumulator is both operands at once, so an add must double it and a subtract must clear it. A conflicting external drive may also be raised in that cycle. The sweep sets acc_to_bus together with load_acc for every preloaded accumulator value and every control setting. It judges the stored result against a model fed with the accumulator as operand A. It judges the conflict flag against the external-drive setting in the same cycle.

// File: rtl/acc_alu_pkg.sv
// Shared types for the accumulator ALU datapath.
// Assumes: mode bit 0 = addition, 1 = bitwise logic.
package acc_alu_pkg;

    typedef enum logic {
        MODE_ARITH = 1'b0,
        MODE_LOGIC = 1'b1
    } alu_mode_e;

    typedef struct packed {
        logic      a_only_n;
        logic      invert_n;
        alu_mode_e mode;
    } alu_ctl_t;

endpackage

// File: rtl/acc_alu_busport.sv
// Bus side of the datapath: picks the bus operand, drives the outgoing
// bus lines with an explicit enable and flags a double drive.
// Assumes only the accumulator and one external source share the bus.
module acc_alu_busport #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] bus_in,
    input  logic [WIDTH-1:0] acc_q,
    input  logic             acc_to_bus,
    input  logic             ext_drive,
    output logic [WIDTH-1:0] opnd_a,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             bus_conflict
);

    // Resolve what the bus carries and what leaves the block.
    always_comb begin
        if (acc_to_bus) begin
            opnd_a  = acc_q;
            bus_out = acc_q;
        end else begin
            opnd_a  = bus_in;
            bus_out = '0;
        end
        bus_oe       = acc_to_bus;
        bus_conflict = acc_to_bus & ext_drive;
    end

endmodule

// File: rtl/acc_alu_prep.sv
// Operand conditioning: applies the invert and A-only controls and
// derives the carry-in. Assumes the core adds or ANDs what comes out.
module acc_alu_prep
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  alu_ctl_t         ctl,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] a_mod,
    output logic [WIDTH-1:0] b_mod,
    output logic             cin,
    output alu_mode_e        mode
);

    // Condition operands: B is neutral for the chosen mode when dropped.
    always_comb begin
        mode  = ctl.mode;
        a_mod = ctl.invert_n ? opnd_a : ~opnd_a;
        if (ctl.a_only_n)
            b_mod = opnd_b;
        else if (ctl.mode == MODE_LOGIC)
            b_mod = '1;
        else
            b_mod = '0;
        cin = (ctl.mode == MODE_ARITH) && !ctl.invert_n;
    end

endmodule

// File: rtl/acc_alu_core.sv
// Result generation: ripple-carry adder and bitwise AND, selected by
// mode. The final carry is not formed, so sums wrap modulo 2**WIDTH.
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_mod,
    input  logic [WIDTH-1:0] b_mod,
    input  logic             cin,
    input  alu_mode_e        mode,
    output logic [WIDTH-1:0] y
);

    logic [WIDTH-1:0] carry;
    logic [WIDTH-1:0] sum;

    assign carry[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i] = a_mod[i] ^ b_mod[i] ^ carry[i];
        if (i < WIDTH - 1) begin : g_carry
            assign carry[i+1] = (a_mod[i] & b_mod[i]) |
                                (carry[i] & (a_mod[i] ^ b_mod[i]));
        end
    end

    // Pick adder or logic result.
    always_comb begin
        if (mode == MODE_LOGIC)
            y = a_mod & b_mod;
        else
            y = sum;
    end

endmodule

// File: rtl/acc_alu_accreg.sv
// Accumulator register with load enable and synchronous active-low reset.
module acc_alu_accreg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Capture the result on load, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/acc_alu_dp.sv
// Top of the accumulator ALU datapath. Bus operand A, accumulator
// operand B, three orthogonal control lines, load strobe and a bus
// drive enable. Assumes all control inputs are synchronous to clk.
module acc_alu_dp
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] bus_in,
    input  logic             ext_drive,
    input  logic             a_only_n,
    input  logic             invert_n,
    input  logic             logic_sel,
    input  logic             load_acc,
    input  logic             acc_to_bus,
    output logic [WIDTH-1:0] alu_y,
    output logic [WIDTH-1:0] acc_q,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             bus_conflict
);

    alu_ctl_t         ctl;
    logic [WIDTH-1:0] opnd_a;
    logic [WIDTH-1:0] a_mod;
    logic [WIDTH-1:0] b_mod;
    logic             cin;
    alu_mode_e        mode;

    // Bundle the control lines.
    always_comb begin
        ctl.a_only_n = a_only_n;
        ctl.invert_n = invert_n;
        ctl.mode     = logic_sel ? MODE_LOGIC : MODE_ARITH;
    end

    acc_alu_busport #(.WIDTH(WIDTH)) u_bus (
        .bus_in      (bus_in),
        .acc_q       (acc_q),
        .acc_to_bus  (acc_to_bus),
        .ext_drive   (ext_drive),
        .opnd_a      (opnd_a),
        .bus_out     (bus_out),
        .bus_oe      (bus_oe),
        .bus_conflict(bus_conflict)
    );

    acc_alu_prep #(.WIDTH(WIDTH)) u_prep (
        .ctl   (ctl),
        .opnd_a(opnd_a),
        .opnd_b(acc_q),
        .a_mod (a_mod),
        .b_mod (b_mod),
        .cin   (cin),
        .mode  (mode)
    );

    acc_alu_core #(.WIDTH(WIDTH)) u_core (
        .a_mod(a_mod),
        .b_mod(b_mod),
        .cin  (cin),
        .mode (mode),
        .y    (alu_y)
    );

    acc_alu_accreg #(.WIDTH(WIDTH)) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load_acc),
        .d    (alu_y),
        .q    (acc_q)
    );

endmodule

// File: rtl/acc_alu_dp_chk.sv
// Property checker for acc_alu_dp, attached by bind below.
module acc_alu_dp_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] bus_in,
    input logic             ext_drive,
    input logic             a_only_n,
    input logic             invert_n,
    input logic             logic_sel,
    input logic             load_acc,
    input logic             acc_to_bus,
    input logic [WIDTH-1:0] alu_y,
    input logic [WIDTH-1:0] acc_q,
    input logic [WIDTH-1:0] bus_out,
    input logic             bus_oe,
    input logic             bus_conflict
);

    logic [WIDTH-1:0] opnd;
    logic             rst_seen;

    assign opnd = acc_to_bus ? acc_q : bus_in;

    // Remember that the previous edge saw reset asserted.
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst_seen |-> acc_q == '0);

    // R3
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!logic_sel && !a_only_n && invert_n) |-> alu_y == opnd);

    // R4
    add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!logic_sel && a_only_n && invert_n) |->
            alu_y == WIDTH'(opnd + acc_q));

    // R8
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_acc |=> acc_q == $past(alu_y));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_acc |=> $stable(acc_q));

    // R9
    bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_to_bus |-> (bus_out == '0 && !bus_oe));

    // R9
    bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_to_bus |-> (bus_out == acc_q && bus_oe));

    // R10
    conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_to_bus && ext_drive) |-> bus_conflict);

endmodule

bind acc_alu_dp acc_alu_dp_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_acc_alu_dp.sv
`timescale 1ns/1ps
module tb_acc_alu_dp;

    localparam int  W      = 4;
    localparam real CLK_NS = 8.0;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] bus_in;
    logic         ext_drive, a_only_n, invert_n, logic_sel;
    logic         load_acc, acc_to_bus;
    logic [W-1:0] alu_y, acc_q, bus_out;
    logic         bus_oe, bus_conflict;

    int vectors = 0;
    int misses  = 0;

    always #(CLK_NS / 2.0) clk = ~clk;

    acc_alu_dp #(.WIDTH(W)) dut (.*);

    // Reference result from the requirement definitions.
    function automatic logic [W-1:0] model(input logic [W-1:0] a,
        input logic [W-1:0] b, input logic an, input logic inn, input logic lg);
        logic [W-1:0] aa, bb;
        if (lg) begin
            aa = inn ? a : ~a;
            bb = an ? b : {W{1'b1}};
            return aa & bb;
        end
        if (an && inn)  return W'(a + b);
        if (an && !inn) return W'(b - a);
        if (!an && inn) return a;
        return W'(0 - a);
    endfunction

    function automatic string tag(input logic an, input logic inn, input logic lg);
        if (lg)          return "R7";
        if (an && inn)   return "R4";
        if (an && !inn)  return "R5";
        if (!an && inn)  return "R3";
        return "R6";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_NS * 150000);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_in = '0; ext_drive = 1'b0;
        a_only_n = 1'b0; invert_n = 1'b1; logic_sel = 1'b0;
        load_acc = 1'b0; acc_to_bus = 1'b0;
        tick(); tick();
        // R1: reset value
        check("R1", "acc after reset", acc_q, '0);
        rst_n = 1'b1;

        for (int p = 0; p < 16; p++) begin
            for (int b = 0; b < 16; b++) begin
                for (int c = 0; c < 8; c++) begin
                    for (int d = 0; d < 2; d++) begin
                        logic an, inn, lg;
                        logic [W-1:0] opa, exp;
                        // Preload the accumulator with pass-through (R3, R8).
                        acc_to_bus = 1'b0; a_only_n = 1'b0; invert_n = 1'b1;
                        logic_sel = 1'b0; load_acc = 1'b1; bus_in = W'(p);
                        ext_drive = 1'b0;
                        tick();
                        check("R8", "preload", acc_q, W'(p));
                        an = c[2]; inn = c[1]; lg = c[0];
                        a_only_n = an; invert_n = inn; logic_sel = lg;
                        bus_in = W'(b); acc_to_bus = d[0];
                        ext_drive = b[0]; load_acc = 1'b1;
                        #1;
                        // R2: operand source follows acc_to_bus
                        opa = d[0] ? W'(p) : W'(b);
                        exp = model(opa, W'(p), an, inn, lg);
                        check(d[0] ? "R2" : tag(an, inn, lg), "alu_y", alu_y, exp);
                        // R9: outgoing bus lines
                        check("R9", "bus_out", bus_out, d[0] ? W'(p) : '0);
                        check("R9", "bus_oe", W'(bus_oe), W'(d[0]));
                        // R10: double drive flag
                        check("R10", "conflict", W'(bus_conflict), W'(d[0] & b[0]));
                        tick();
                        check("R8", "load", acc_q, exp);
                        // R8: hold while inputs move
                        load_acc = 1'b0; bus_in = ~W'(b); acc_to_bus = ~d[0];
                        tick();
                        check("R8", "hold", acc_q, exp);
                    end
                end
            end
        end

        // R1: reset overrides a pending load
        load_acc = 1'b1; acc_to_bus = 1'b0; a_only_n = 1'b0;
        invert_n = 1'b1; logic_sel = 1'b0; bus_in = 4'hA;
        tick();
        check("R8", "pre-reset load", acc_q, 4'hA);
        rst_n = 1'b0;
        tick();
        check("R1", "reset over load", acc_q, '0);
        rst_n = 1'b1; load_acc = 1'b0;
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule